// File: doc/BRIEF.md
# Sequential Hardware Break Comparator

This block watches a processor's bus-monitor stream and raises a break request when programmed conditions are met. Each monitored cycle carries a fetch/operand flag, an address (the program counter on fetches), data, access size, direction, the current address-space identifier, a strobe for execution of the TLB-load instruction and a flag for accesses to the on-chip I/O area. Five comparator channels examine that stream. They differ in capability. Channel 1 is the only one that compares data. Channels 1 to 4 compare address and direction. Channel 5 has no address or data comparator and watches the TLB-load strobe and the I/O-access flag instead. Every channel can also qualify on the identifier.

Channels either break on their own or are chained into an ordered sequence: 2 then 1, 3-2-1, or 4-3-2-1. In a chained mode only the last channel of a completed sequence produces the break. Channels outside the chain keep breaking on their own. The break request is a one-cycle pulse. A sticky cause vector shows which channel or which sequence produced each break until software clears it. All settings are loaded through a simple write port.

Top module: `brk_seq_unit`

## Requirements
- R1: After reset, `brk_req` is 0, `brk_cause` is 0, every channel is disabled and chaining is off.
- R2: A channel 1-4 address condition (control bit1) matches when the monitored address equals the programmed address in every bit where the mask register holds 0. Control bit2 picks the cycle type: 1 for fetch cycles, 0 for operand cycles. A cycle of the other type does not match.
- R3: The channel 1 data condition (control bit6) matches only on operand cycles whose size equals the programmed size in control bits 8:7 (0 byte, 1 word, 2 long). For byte size only data bits 7:0 are compared, for word size bits 15:0, and for long size all bits.
- R4: Control bits 4:3 qualify direction on channels 1-4. A value of 1 accepts only operand reads, 2 accepts only operand writes, and 0 or 3 accepts any cycle.
- R5: With control bit5 set, a channel matches only when the monitored identifier equals control bits 23:16.
- R6: Channel 5 matches on the TLB-load strobe when control bit9 is set, and on an I/O-area access when control bit10 is set. If both are set, either event matches. Address bits in its control word have no effect.
- R7: With chaining off (mode register at word 20 holding 0), a match on any enabled channel (control bit0) during a valid cycle produces a break and sets cause bit n-1 for channel n.
- R8: Mode values 1, 2 and 3 chain channels 2-1, 3-2-1 and 4-3-2-1. A break with cause bit5 occurs only when channel 1 matches after the earlier chain members have matched in descending order. The progress then restarts.
- R9: A match by a chain member that is not the next one expected leaves the sequence progress unchanged.
- R10: Any configuration write other than to the clear word (word 21) discards sequence progress.
- R11: `brk_req` is high for one cycle, in the cycle after the triggering monitor cycle. A trigger in the cycle right after a pulse produces no new pulse.
- R12: Cause bits stay set until a write to word 21 with 1 in the matching bit. A cause that is set in the same cycle as its clear stays set.
- R13: In a chained mode, channels outside the chain (and channel 5 always) still break on their own. Such a break can coincide with a sequence completion in one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Word index: channel n at 4(n-1)+{0 control,1 address,2 mask,3 data}, 20 mode, 21 cause clear |
| cfg_wdata | input | 32 | Configuration write data |
| mon_valid | input | 1 | Monitored cycle is valid |
| mon_fetch | input | 1 | 1 for instruction fetch, 0 for operand access |
| mon_addr | input | ADDR_W | Fetch PC or operand address |
| mon_data | input | DATA_W | Operand data |
| mon_size | input | 2 | Access size: 0 byte, 1 word, 2 long |
| mon_read | input | 1 | 1 for read, 0 for write |
| mon_asid | input | 8 | Address-space identifier |
| mon_ldtlb | input | 1 | TLB-load instruction executed |
| mon_ioacc | input | 1 | Access to the on-chip I/O area |
| brk_req | output | 1 | One-cycle break request |
| brk_cause | output | 6 | Sticky cause: bits 4:0 channels 5..1, bit5 sequence |

## Verification
The case of interest is a sequence completion and an independent channel break in the same cycle. The bench chains 2-1 and arms channel 5 for I/O accesses. It then presents channel 2's address, and after that a single fetch that hits channel 1's address while flagging an I/O access. It expects exactly one pulse with cause bits 5 and 4 both set. A separate directed step applies a cause-clear write in the same cycle as a matching bus cycle and expects the new cause to survive.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int NCH      = 5;
    localparam int NADDR    = 4;
    localparam int ASID_W   = 8;
    localparam int CFG_AW   = 5;
    localparam int REG_SPAN = 4;
    localparam int SEQ_REG  = NCH * REG_SPAN;
    localparam int CLR_REG  = SEQ_REG + 1;
    localparam int NCAUSE   = NCH + 1;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_RSVD = 2'd3} size_e;
    typedef enum logic [1:0] {SEQ_OFF = 2'd0, SEQ_2 = 2'd1, SEQ_3 = 2'd2, SEQ_4 = 2'd3} seq_e;
    typedef enum logic [1:0] {RW_ANY = 2'd0, RW_RD = 2'd1, RW_WR = 2'd2, RW_BOTH = 2'd3} rw_e;

    typedef struct packed {
        logic              en;
        logic              use_addr;
        logic              pc_type;
        rw_e               rw;
        logic              use_asid;
        logic              use_data;
        size_e             size;
        logic              ev_ldtlb;
        logic              ev_io;
        logic [ASID_W-1:0] asid;
    } chan_ctrl_t;

    function automatic chan_ctrl_t ctrl_unpack(input logic [31:0] w);
        chan_ctrl_t c;
        c.en       = w[0];
        c.use_addr = w[1];
        c.pc_type  = w[2];
        c.rw       = rw_e'(w[4:3]);
        c.use_asid = w[5];
        c.use_data = w[6];
        c.size     = size_e'(w[8:7]);
        c.ev_ldtlb = w[9];
        c.ev_io    = w[10];
        c.asid     = w[16 +: ASID_W];
        return c;
    endfunction

endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [CFG_AW-1:0]      addr,
    input  logic [31:0]            wdata,
    output chan_ctrl_t             ctrl     [NCH],
    output logic [ADDR_W-1:0]      addr_val [NADDR],
    output logic [ADDR_W-1:0]      mask_val [NADDR],
    output logic [DATA_W-1:0]      data_val,
    output seq_e                   mode,
    output logic                   seq_clr,
    output logic [NCAUSE-1:0]      clr_mask
);

    localparam logic [CFG_AW-1:0] SEQ_IDX = CFG_AW'(SEQ_REG);
    localparam logic [CFG_AW-1:0] CLR_IDX = CFG_AW'(CLR_REG);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) ctrl[i] <= '0;
            for (int i = 0; i < NADDR; i++) begin
                addr_val[i] <= '0;
                mask_val[i] <= '0;
            end
            data_val <= '0;
            mode     <= SEQ_OFF;
        end else if (we) begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == CFG_AW'(i * REG_SPAN)) ctrl[i] <= ctrl_unpack(wdata);
            end
            for (int i = 0; i < NADDR; i++) begin
                if (addr == CFG_AW'(i * REG_SPAN + 1)) addr_val[i] <= wdata[ADDR_W-1:0];
                if (addr == CFG_AW'(i * REG_SPAN + 2)) mask_val[i] <= wdata[ADDR_W-1:0];
            end
            if (addr == CFG_AW'(3)) data_val <= wdata[DATA_W-1:0];
            if (addr == SEQ_IDX) mode <= seq_e'(wdata[1:0]);
        end
    end

    always_comb begin
        seq_clr  = we && (addr != CLR_IDX);
        clr_mask = (we && addr == CLR_IDX) ? wdata[NCAUSE-1:0] : '0;
    end

endmodule

// File: rtl/brk_chan_match.sv
module brk_chan_match
    import brk_pkg::*;
#(
    parameter int CH     = 1,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  chan_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0]   cmp_addr,
    input  logic [ADDR_W-1:0]   cmp_mask,
    input  logic [DATA_W-1:0]   cmp_data,
    input  logic                mon_valid,
    input  logic                mon_fetch,
    input  logic [ADDR_W-1:0]   mon_addr,
    input  logic [DATA_W-1:0]   mon_data,
    input  logic [1:0]          mon_size,
    input  logic                mon_read,
    input  logic [ASID_W-1:0]   mon_asid,
    input  logic                mon_ldtlb,
    input  logic                mon_ioacc,
    output logic                hit
);

    localparam bit HAS_ADDR = (CH <= NADDR);
    localparam bit HAS_DATA = (CH == 1);
    localparam bit HAS_EVT  = (CH == NCH);

    logic addr_ok, data_ok, rw_ok, asid_ok, evt_ok;

    assign asid_ok = !ctrl.use_asid || (mon_asid == ctrl.asid);

    generate
        if (HAS_ADDR) begin : g_addr
            always_comb begin
                addr_ok = !ctrl.use_addr ||
                          ((ctrl.pc_type == mon_fetch) &&
                           (((mon_addr ^ cmp_addr) & ~cmp_mask) == '0));
                case (ctrl.rw)
                    RW_RD:   rw_ok = !mon_fetch && mon_read;
                    RW_WR:   rw_ok = !mon_fetch && !mon_read;
                    default: rw_ok = 1'b1;
                endcase
            end
        end else begin : g_no_addr
            assign addr_ok = 1'b1;
            assign rw_ok   = 1'b1;
        end

        if (HAS_DATA) begin : g_data
            logic [DATA_W-1:0] keep;
            always_comb begin
                for (int i = 0; i < DATA_W; i++) begin
                    case (ctrl.size)
                        SZ_BYTE: keep[i] = (i < 8);
                        SZ_WORD: keep[i] = (i < 16);
                        default: keep[i] = 1'b1;
                    endcase
                end
                data_ok = !ctrl.use_data ||
                          (!mon_fetch && (mon_size == 2'(ctrl.size)) &&
                           (((mon_data ^ cmp_data) & keep) == '0));
            end
        end else begin : g_no_data
            assign data_ok = 1'b1;
        end

        if (HAS_EVT) begin : g_evt
            assign evt_ok = (!ctrl.ev_ldtlb && !ctrl.ev_io) ||
                            (ctrl.ev_ldtlb && mon_ldtlb) ||
                            (ctrl.ev_io && mon_ioacc);
        end else begin : g_no_evt
            assign evt_ok = 1'b1;
        end
    endgenerate

    assign hit = ctrl.en && mon_valid && addr_ok && data_ok && rw_ok && asid_ok && evt_ok;

endmodule

// File: rtl/brk_sequencer.sv
module brk_sequencer
    import brk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  seq_e            mode,
    input  logic            seq_clr,
    input  logic [NCH-1:0]  hit,
    output logic [NCH-1:0]  indep_hit,
    output logic            seq_done,
    output logic [1:0]      stage
);

    logic [2:0] chain_len;
    logic [1:0] exp_idx;
    logic       active, exp_hit, last;

    always_comb begin
        active    = (mode != SEQ_OFF);
        chain_len = active ? ({1'b0, mode} + 3'd1) : 3'd0;
        exp_idx   = 2'(chain_len - 3'd1 - {1'b0, stage});
        exp_hit   = active && hit[exp_idx];
        last      = (exp_idx == 2'd0);
        seq_done  = exp_hit && last && !seq_clr;
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_indep
            assign indep_hit[i] = hit[i] && !(i < chain_len);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || seq_clr) begin
            stage <= 2'd0;
        end else if (exp_hit) begin
            stage <= last ? 2'd0 : stage + 2'd1;
        end
    end

endmodule

// File: rtl/brk_seq_unit.sv
module brk_seq_unit
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [4:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic                mon_valid,
    input  logic                mon_fetch,
    input  logic [ADDR_W-1:0]   mon_addr,
    input  logic [DATA_W-1:0]   mon_data,
    input  logic [1:0]          mon_size,
    input  logic                mon_read,
    input  logic [7:0]          mon_asid,
    input  logic                mon_ldtlb,
    input  logic                mon_ioacc,
    output logic                brk_req,
    output logic [5:0]          brk_cause
);

    chan_ctrl_t          ctrl     [NCH];
    logic [ADDR_W-1:0]   addr_val [NADDR];
    logic [ADDR_W-1:0]   mask_val [NADDR];
    logic [DATA_W-1:0]   data_val;
    seq_e                seq_mode;
    logic                seq_clr;
    logic [NCAUSE-1:0]   clr_mask;
    logic [NCH-1:0]      hit, indep_hit;
    logic                seq_done;
    logic [1:0]          seq_stage;
    logic                trig;
    logic [NCAUSE-1:0]   cause_q;

    brk_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl(ctrl), .addr_val(addr_val), .mask_val(mask_val), .data_val(data_val),
        .mode(seq_mode), .seq_clr(seq_clr), .clr_mask(clr_mask)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            logic [ADDR_W-1:0] c_addr, c_mask;
            logic [DATA_W-1:0] c_data;
            if (g < NADDR) begin : g_a
                assign c_addr = addr_val[g];
                assign c_mask = mask_val[g];
            end else begin : g_na
                assign c_addr = '0;
                assign c_mask = '0;
            end
            if (g == 0) begin : g_d
                assign c_data = data_val;
            end else begin : g_nd
                assign c_data = '0;
            end
            brk_chan_match #(.CH(g + 1), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
                .ctrl(ctrl[g]), .cmp_addr(c_addr), .cmp_mask(c_mask), .cmp_data(c_data),
                .mon_valid(mon_valid), .mon_fetch(mon_fetch), .mon_addr(mon_addr),
                .mon_data(mon_data), .mon_size(mon_size), .mon_read(mon_read),
                .mon_asid(mon_asid), .mon_ldtlb(mon_ldtlb), .mon_ioacc(mon_ioacc),
                .hit(hit[g])
            );
        end
    endgenerate

    brk_sequencer u_seq (
        .clk(clk), .rst(rst), .mode(seq_mode), .seq_clr(seq_clr), .hit(hit),
        .indep_hit(indep_hit), .seq_done(seq_done), .stage(seq_stage)
    );

    assign trig = (|indep_hit) || seq_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_req <= 1'b0;
            cause_q <= '0;
        end else begin
            brk_req <= trig && !brk_req;
            cause_q <= (cause_q & ~clr_mask) | {seq_done, indep_hit};
        end
    end

    assign brk_cause = cause_q;

endmodule

// File: rtl/brk_seq_unit_chk.sv
module brk_seq_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [4:0] cfg_addr,
    input logic       brk_req,
    input logic [5:0] brk_cause,
    input logic [1:0] seq_stage,
    input logic [1:0] seq_mode
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!brk_req && brk_cause == 6'd0));

    p_cause_with_req_r7: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> (brk_cause != 6'd0));

    p_stage_range_r8: assert property (@(posedge clk) disable iff (rst)
        seq_stage <= seq_mode);

    p_cfg_clears_seq_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr != 5'd21) |=> (seq_stage == 2'd0));

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        brk_req |=> !brk_req);

    p_cause_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_addr == 5'd21) |=> ((brk_cause & $past(brk_cause)) == $past(brk_cause)));

endmodule

bind brk_seq_unit brk_seq_unit_chk u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .brk_req(brk_req), .brk_cause(brk_cause),
    .seq_stage(seq_stage), .seq_mode(seq_mode)
);

// File: tb/tb_brk_seq_unit.sv
module tb_brk_seq_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mon_valid = 1'b0, mon_fetch = 1'b0, mon_read = 1'b0;
    logic        mon_ldtlb = 1'b0, mon_ioacc = 1'b0;
    logic [31:0] mon_addr = '0, mon_data = '0;
    logic [1:0]  mon_size = '0;
    logic [7:0]  mon_asid = '0;
    logic        brk_req;
    logic [5:0]  brk_cause;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    brk_seq_unit dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mon_valid(mon_valid), .mon_fetch(mon_fetch), .mon_addr(mon_addr), .mon_data(mon_data),
        .mon_size(mon_size), .mon_read(mon_read), .mon_asid(mon_asid),
        .mon_ldtlb(mon_ldtlb), .mon_ioacc(mon_ioacc),
        .brk_req(brk_req), .brk_cause(brk_cause)
    );

    function automatic logic [31:0] mk(input logic en, ua, pc, input logic [1:0] rw,
                                       input logic uas, ud, input logic [1:0] sz,
                                       input logic el, ei, input logic [7:0] asid);
        return {8'h0, asid, 5'h0, ei, el, sz, ud, uas, rw, pc, ua, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_brk(input string req, input logic r, input logic [5:0] c);
        chk(req, {31'd0, brk_req}, {31'd0, r});
        chk(req, {26'd0, brk_cause}, {26'd0, c});
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_bus(input logic f, input logic [31:0] a, d, input logic [1:0] sz,
                           input logic rd, input logic [7:0] asid, input logic lt, io);
        mon_valid = 1'b1; mon_fetch = f; mon_addr = a; mon_data = d; mon_size = sz;
        mon_read = rd; mon_asid = asid; mon_ldtlb = lt; mon_ioacc = io;
    endtask

    task automatic beat(input logic f, input logic [31:0] a, d, input logic [1:0] sz,
                        input logic rd, input logic [7:0] asid, input logic lt, io);
        set_bus(f, a, d, sz, rd, asid, lt, io);
        @(posedge clk); @(negedge clk);
        mon_valid = 1'b0; mon_ldtlb = 1'b0; mon_ioacc = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] a);
        beat(1'b1, a, 32'h0, 2'd2, 1'b1, 8'h0, 1'b0, 1'b0);
    endtask

    task automatic clr_cause();
        wr(5'd21, 32'h3F);
    endtask

    task automatic dis_all();
        for (int i = 0; i < 5; i++) wr(5'(i * 4), 32'h0);
        wr(5'd20, 32'h0);
        clr_cause();
    endtask

    task automatic t_reset();
        expect_brk("R1 reset", 1'b0, 6'h00);
    endtask

    task automatic t_addr();
        wr(5'd5, 32'h1000); wr(5'd6, 32'h0000_000F);
        wr(5'd4, mk(1, 1, 1, 0, 0, 0, 0, 0, 0, 0));
        fetch(32'h1008);
        expect_brk("R2 masked fetch address hit", 1'b1, 6'h02);
        clr_cause();
        expect_brk("R12 cause cleared", 1'b0, 6'h00);
        beat(1'b0, 32'h1008, 0, 2'd2, 1'b1, 0, 0, 0);
        expect_brk("R2 operand cycle vs fetch type", 1'b0, 6'h00);
        fetch(32'h1010);
        expect_brk("R2 unmasked bit differs", 1'b0, 6'h00);
        wr(5'd4, mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        beat(1'b0, 32'h100C, 0, 2'd2, 1'b0, 0, 0, 0);
        expect_brk("R2 operand type hit R7", 1'b1, 6'h02);
        dis_all();
    endtask

    task automatic t_data();
        wr(5'd3, 32'h0000_00A5);
        wr(5'd0, mk(1, 0, 0, 0, 0, 1, 2'd0, 0, 0, 0));
        beat(1'b0, 32'h5000, 32'hFFFF_12A5, 2'd0, 1'b0, 0, 0, 0);
        expect_brk("R3 byte lane hit", 1'b1, 6'h01);
        clr_cause();
        beat(1'b0, 32'h5000, 32'hFFFF_12A5, 2'd1, 1'b0, 0, 0, 0);
        expect_brk("R3 size mismatch", 1'b0, 6'h00);
        beat(1'b0, 32'h5000, 32'hFFFF_12A4, 2'd0, 1'b0, 0, 0, 0);
        expect_brk("R3 byte value differs", 1'b0, 6'h00);
        wr(5'd3, 32'h0000_12A5);
        wr(5'd0, mk(1, 0, 0, 0, 0, 1, 2'd1, 0, 0, 0));
        beat(1'b0, 32'h5000, 32'hABCD_12A5, 2'd1, 1'b1, 0, 0, 0);
        expect_brk("R3 word lanes hit", 1'b1, 6'h01);
        clr_cause();
        beat(1'b0, 32'h5000, 32'hABCD_13A5, 2'd1, 1'b1, 0, 0, 0);
        expect_brk("R3 word value differs", 1'b0, 6'h00);
        dis_all();
    endtask

    task automatic t_rw();
        wr(5'd8, mk(1, 0, 0, 2'd1, 0, 0, 0, 0, 0, 0));
        beat(1'b0, 32'h20, 0, 2'd2, 1'b1, 0, 0, 0);
        expect_brk("R4 read accepted", 1'b1, 6'h04);
        clr_cause();
        beat(1'b0, 32'h20, 0, 2'd2, 1'b0, 0, 0, 0);
        expect_brk("R4 write rejected", 1'b0, 6'h00);
        fetch(32'h20);
        expect_brk("R4 fetch rejected", 1'b0, 6'h00);
        wr(5'd8, mk(1, 0, 0, 2'd2, 0, 0, 0, 0, 0, 0));
        beat(1'b0, 32'h20, 0, 2'd2, 1'b0, 0, 0, 0);
        expect_brk("R4 write accepted", 1'b1, 6'h04);
        dis_all();
    endtask

    task automatic t_asid();
        wr(5'd12, mk(1, 0, 0, 0, 1, 0, 0, 0, 0, 8'h3C));
        beat(1'b0, 32'h40, 0, 2'd2, 1'b1, 8'h3C, 0, 0);
        expect_brk("R5 identifier equal", 1'b1, 6'h08);
        clr_cause();
        beat(1'b0, 32'h40, 0, 2'd2, 1'b1, 8'h3D, 0, 0);
        expect_brk("R5 identifier differs", 1'b0, 6'h00);
        dis_all();
    endtask

    task automatic t_ch5();
        wr(5'd16, mk(1, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        beat(1'b1, 32'h60, 0, 2'd2, 1'b1, 0, 1'b1, 1'b0);
        expect_brk("R6 TLB-load event", 1'b1, 6'h10);
        clr_cause();
        beat(1'b0, 32'h60, 0, 2'd2, 1'b1, 0, 1'b0, 1'b1);
        expect_brk("R6 I/O not selected", 1'b0, 6'h00);
        wr(5'd16, mk(1, 1, 1, 0, 0, 0, 0, 0, 1, 0));
        beat(1'b0, 32'h9999, 0, 2'd2, 1'b0, 0, 1'b0, 1'b1);
        expect_brk("R6 I/O event, address bits ignored", 1'b1, 6'h10);
        dis_all();
    endtask

    task automatic setup_chain();
        wr(5'd1, 32'h100); wr(5'd2, 32'h0);
        wr(5'd5, 32'h200); wr(5'd6, 32'h0);
        wr(5'd9, 32'h300); wr(5'd10, 32'h0);
        wr(5'd13, 32'h400); wr(5'd14, 32'h0);
        for (int i = 0; i < 4; i++) wr(5'(i * 4), mk(1, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_seq();
        setup_chain();
        wr(5'd20, 32'd1);
        fetch(32'h100);
        expect_brk("R9 channel 1 first, no break", 1'b0, 6'h00);
        fetch(32'h200);
        expect_brk("R8 channel 2 armed", 1'b0, 6'h00);
        fetch(32'h100);
        expect_brk("R8 2-1 sequence break", 1'b1, 6'h20);
        clr_cause();
        fetch(32'h100);
        expect_brk("R8 progress restarts", 1'b0, 6'h00);
        wr(5'd20, 32'd2);
        fetch(32'h300); fetch(32'h100);
        expect_brk("R9 out of order ignored", 1'b0, 6'h00);
        fetch(32'h200); fetch(32'h100);
        expect_brk("R8 3-2-1 sequence break", 1'b1, 6'h20);
        clr_cause();
        wr(5'd20, 32'd3);
        fetch(32'h400); fetch(32'h300); fetch(32'h400); fetch(32'h200);
        expect_brk("R9 repeated channel 4 ignored", 1'b0, 6'h00);
        fetch(32'h100);
        expect_brk("R8 4-3-2-1 sequence break", 1'b1, 6'h20);
        clr_cause();
        wr(5'd20, 32'd1);
        fetch(32'h200);
        wr(5'd1, 32'h100);
        fetch(32'h100);
        expect_brk("R10 rewrite discards progress", 1'b0, 6'h00);
        fetch(32'h200); fetch(32'h100);
        expect_brk("R10 sequence after rewrite", 1'b1, 6'h20);
        clr_cause();
    endtask

    task automatic t_pulse();
        wr(5'd20, 32'd0);
        fetch(32'h100);
        expect_brk("R11 first pulse R7", 1'b1, 6'h01);
        fetch(32'h100);
        expect_brk("R11 back-to-back suppressed", 1'b0, 6'h01);
    endtask

    task automatic t_sticky();
        wr(5'd21, 32'h0);
        expect_brk("R12 zero clear keeps cause", 1'b0, 6'h01);
        wr(5'd21, 32'h1);
        expect_brk("R12 clear bit 0", 1'b0, 6'h00);
        cfg_we = 1'b1; cfg_addr = 5'd21; cfg_wdata = 32'h1;
        set_bus(1'b1, 32'h100, 0, 2'd2, 1'b1, 0, 0, 0);
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0; mon_valid = 1'b0;
        expect_brk("R12 set wins over clear", 1'b1, 6'h01);
        dis_all();
    endtask

    task automatic t_overlap();
        setup_chain();
        wr(5'd12, 32'h0);
        wr(5'd16, mk(1, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        wr(5'd20, 32'd1);
        fetch(32'h300);
        expect_brk("R13 channel 3 outside chain", 1'b1, 6'h04);
        clr_cause();
        fetch(32'h200);
        expect_brk("R13 chain armed", 1'b0, 6'h00);
        beat(1'b1, 32'h100, 0, 2'd2, 1'b1, 0, 1'b0, 1'b1);
        expect_brk("R13 sequence and channel 5 together", 1'b1, 6'h30);
        dis_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_addr();
        t_data();
        t_rw();
        t_asid();
        t_ch5();
        t_seq();
        t_pulse();
        t_sticky();
        t_overlap();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule